// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block derives the serial-clock timing of an I2C master from the system clock. It chains three counters. A half-period counter wraps every thp+1 cycles. A power-of-two stage then divides by 2^N. A decimal stage divides by ten times (M+1). Each wrap of the last stage ends one half period of the serial clock. The block then pulses a toggle strobe and inverts its serial-clock level. Midway through every half period it pulses a mid strobe. The master state machine uses that strobe to change SDA while the clock is low and to sample SDA while it is high.

Software writes two values through a small write port. The first is an 8-bit half-period value. The second is a control byte that carries M and N. Writes land in shadow registers. The counters use them only at the next half-period boundary, or at once while the divider is disabled. A half period is therefore never cut short or stretched by a write. The half period in system cycles is (thp+1) * 2^N * 10 * (M+1), so the serial clock runs at f_sys / (2(thp+1)) / 2^N / (M+1) / 10. Choosing the best divisor values is left to software.

Top module: `i2c_sclk_div`

## Requirements
- R1: After reset `scl_o` is 1, and `tgl_o` and `mid_o` are 0.
- R2: While enabled, consecutive `tgl_o` pulses are exactly P = (thp+1) * 2^N * 10 * (M+1) cycles apart, and `scl_o` inverts in the same cycle as each `tgl_o` pulse and at no other time.
- R3: When `en_i` is first sampled high on a clock edge, counted as cycle 1, the first `tgl_o` pulse is seen after cycle P and the first `mid_o` pulse after cycle P/2.
- R4: Exactly one `mid_o` pulse falls between two `tgl_o` pulses, P/2 cycles after the earlier one, and it never coincides with `tgl_o`.
- R5: In the control byte, bits 6:3 hold M and bits 2:0 hold N, and bit 7 has no effect on timing.
- R6: A half-period value below 5 gives the same timing as a value of 5.
- R7: An M value below 2 gives the same timing as M = 2.
- R8: Values written while enabled leave the running half period unchanged and take effect from the half period that starts after the next `tgl_o` pulse.
- R9: While `en_i` is low, all counters are held cleared, `tgl_o` and `mid_o` stay 0 and `scl_o` is 1. After re-enabling, timing restarts as in R3.
- R10: Values written while `en_i` is low govern the very first half period after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bus enable; low holds the divider cleared |
| wr_thp_i | input | 1 | Write strobe for the half-period value |
| wr_ctl_i | input | 1 | Write strobe for the control byte (M in 6:3, N in 2:0) |
| wdata_i | input | 8 | Write data for either register |
| scl_o | output | 1 | Serial-clock level, high when idle |
| tgl_o | output | 1 | One-cycle strobe at each half-period boundary |
| mid_o | output | 1 | One-cycle strobe at the middle of each half period |

## Verification
The bench measures the exact cycle of the first toggle and mid strobe after enabling. A design that started its counters one step late, or loaded a count of thp instead of thp+1, would be off by a fixed number of cycles. It also programs settings with N above zero, with bit 7 set, with a half-period value under the floor and with M under its floor. A swapped field, a missing clamp or a broken power-of-two mask would show up as a wrong period. Writes made halfway through a running half period must leave that period at its old length. A divider that reloaded at once would shorten or stretch it. Dropping the enable halfway must force the clock high and silence both strobes. Re-enabling must then produce a full first half period, not a leftover partial count.

// File: rtl/sclk_div_pkg.sv
`timescale 1ns/1ps
package sclk_div_pkg;
  // control byte field positions
  localparam int unsigned CTL_N_LSB = 0;
  localparam int unsigned CTL_M_LSB = 3;

  localparam int unsigned DEF_THP_W   = 8;
  localparam int unsigned DEF_M_W     = 4;
  localparam int unsigned DEF_N_W     = 3;
  localparam int unsigned DEF_DEC     = 10;
  localparam int unsigned DEF_THP_MIN = 5;
  localparam int unsigned DEF_M_MIN   = 2;

  // shortest half period the clamps allow
  localparam int unsigned DEF_P_MIN = (DEF_THP_MIN + 1) * DEF_DEC * (DEF_M_MIN + 1);
endpackage

// File: rtl/sclk_cfg.sv
`timescale 1ns/1ps
module sclk_cfg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned THP_W   = 8,
  parameter int unsigned M_W     = 4,
  parameter int unsigned N_W     = 3,
  parameter int unsigned THP_MIN = 5,
  parameter int unsigned M_MIN   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_thp_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [THP_W-1:0]  thp_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o
);
  import sclk_div_pkg::*;

  localparam logic [THP_W-1:0] THP_FLOOR = THP_W'(THP_MIN);
  localparam logic [M_W-1:0]   M_FLOOR   = M_W'(M_MIN);

  logic [THP_W-1:0] thp_sh_q, thp_act_q, thp_clamp;
  logic [M_W-1:0]   m_sh_q, m_act_q, m_clamp;
  logic [N_W-1:0]   n_sh_q, n_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thp_sh_q <= THP_FLOOR;
      m_sh_q   <= M_FLOOR;
      n_sh_q   <= '0;
    end else begin
      if (wr_thp_i) thp_sh_q <= wdata_i[THP_W-1:0];
      if (wr_ctl_i) begin
        m_sh_q <= wdata_i[CTL_M_LSB +: M_W];
        n_sh_q <= wdata_i[CTL_N_LSB +: N_W];
      end
    end
  end

  assign thp_clamp = (thp_sh_q < THP_FLOOR) ? THP_FLOOR : thp_sh_q;
  assign m_clamp   = (m_sh_q < M_FLOOR) ? M_FLOOR : m_sh_q;

  // active copy moves only at a boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thp_act_q <= THP_FLOOR;
      m_act_q   <= M_FLOOR;
      n_act_q   <= '0;
    end else if (load_i) begin
      thp_act_q <= thp_clamp;
      m_act_q   <= m_clamp;
      n_act_q   <= n_sh_q;
    end
  end

  assign thp_o = thp_act_q;
  assign m_o   = m_act_q;
  assign n_o   = n_act_q;
endmodule

// File: rtl/sclk_hp_stage.sv
`timescale 1ns/1ps
module sclk_hp_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = run_i && (cnt_q == lim_i);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sclk_pow2_stage.sv
`timescale 1ns/1ps
module sclk_pow2_stage #(
  parameter int unsigned N_W = 3,
  localparam int unsigned CW = (1 << N_W) - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           step_i,
  input  logic [N_W-1:0] n_i,
  output logic           tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          wrap;

  // lim = 2^n - 1 as a thermometer mask
  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign lim[i] = (N_W'(i) < n_i);
  end

  assign wrap   = step_i && (cnt_q == lim);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sclk_dec_stage.sv
`timescale 1ns/1ps
module sclk_dec_stage #(
  parameter int unsigned M_W    = 4,
  parameter int unsigned FACTOR = 10,
  localparam int unsigned CW = $clog2(FACTOR * (1 << M_W) + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           step_i,
  input  logic [M_W-1:0] m_i,
  output logic           tick_o,
  output logic           mid_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mult, lim, half;
  logic          wrap;

  assign mult = CW'(m_i) + CW'(1);
  assign lim  = CW'(FACTOR) * mult - CW'(1);
  assign half = CW'(FACTOR / 2) * mult - CW'(1);

  assign wrap   = step_i && (cnt_q == lim);
  assign tick_o = wrap;
  assign mid_o  = step_i && (cnt_q == half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_sclk_div.sv
`timescale 1ns/1ps
module i2c_sclk_div #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned THP_W   = sclk_div_pkg::DEF_THP_W,
  parameter int unsigned M_W     = sclk_div_pkg::DEF_M_W,
  parameter int unsigned N_W     = sclk_div_pkg::DEF_N_W,
  parameter int unsigned DEC     = sclk_div_pkg::DEF_DEC,
  parameter int unsigned THP_MIN = sclk_div_pkg::DEF_THP_MIN,
  parameter int unsigned M_MIN   = sclk_div_pkg::DEF_M_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_thp_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              scl_o,
  output logic              tgl_o,
  output logic              mid_o
);
  logic [THP_W-1:0] thp;
  logic [M_W-1:0]   m_val;
  logic [N_W-1:0]   n_val;
  logic             hp_tick, p2_tick, half_end, half_mid;
  logic             scl_q, tgl_q, mid_q;

  sclk_cfg #(
    .DATA_W(DATA_W), .THP_W(THP_W), .M_W(M_W), .N_W(N_W),
    .THP_MIN(THP_MIN), .M_MIN(M_MIN)
  ) u_cfg (
    .clk_i, .rst_ni,
    .wr_thp_i, .wr_ctl_i, .wdata_i,
    .load_i(!en_i || half_end),
    .thp_o(thp), .m_o(m_val), .n_o(n_val)
  );

  sclk_hp_stage #(.W(THP_W)) u_hp (
    .clk_i, .rst_ni, .run_i(en_i), .lim_i(thp), .tick_o(hp_tick)
  );

  sclk_pow2_stage #(.N_W(N_W)) u_p2 (
    .clk_i, .rst_ni, .run_i(en_i), .step_i(hp_tick), .n_i(n_val), .tick_o(p2_tick)
  );

  sclk_dec_stage #(.M_W(M_W), .FACTOR(DEC)) u_dec (
    .clk_i, .rst_ni, .run_i(en_i), .step_i(p2_tick), .m_i(m_val),
    .tick_o(half_end), .mid_o(half_mid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      tgl_q <= 1'b0;
      mid_q <= 1'b0;
    end else if (!en_i) begin
      scl_q <= 1'b1;
      tgl_q <= 1'b0;
      mid_q <= 1'b0;
    end else begin
      scl_q <= scl_q ^ half_end;
      tgl_q <= half_end;
      mid_q <= half_mid;
    end
  end

  assign scl_o = scl_q;
  assign tgl_o = tgl_q;
  assign mid_o = mid_q;
endmodule

// File: rtl/sclk_div_chk.sv
`timescale 1ns/1ps
module sclk_div_chk #(
  parameter int unsigned P_MIN = sclk_div_pkg::DEF_P_MIN
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_o,
  input logic tgl_o,
  input logic mid_o
);
  logic [31:0] gap_q;
  logic        seen_q, armed_q, mid_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; seen_q <= 1'b0; armed_q <= 1'b0; mid_seen_q <= 1'b0;
    end else begin
      if (tgl_o) begin
        gap_q <= '0; seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 32'd1;
      end
      if (!en_i) begin
        armed_q <= 1'b0; mid_seen_q <= 1'b0;
      end else if (tgl_o) begin
        armed_q <= 1'b1; mid_seen_q <= 1'b0;
      end else if (mid_o) begin
        mid_seen_q <= 1'b1;
      end
    end
  end

  assert_idle_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tgl_o && !mid_o && scl_o));

  assert_scl_flip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_o |-> (scl_o != $past(scl_o)));

  assert_scl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !tgl_o) |-> $stable(scl_o));

  assert_mid_apart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_o |-> !mid_o);

  assert_mid_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_o && armed_q) |-> mid_seen_q);

  assert_min_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_o && seen_q) |-> (gap_q >= 32'(P_MIN - 1)));
endmodule

bind i2c_sclk_div sclk_div_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .scl_o(scl_o), .tgl_o(tgl_o), .mid_o(mid_o)
);

// File: tb/tb_i2c_sclk_div.sv
`timescale 1ns/1ps
module tb_i2c_sclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_thp = 1'b0;
  logic       wr_ctl = 1'b0;
  logic [7:0] wdata = '0;
  logic       scl, tgl, mid;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  i2c_sclk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .wr_thp_i(wr_thp), .wr_ctl_i(wr_ctl), .wdata_i(wdata),
    .scl_o(scl), .tgl_o(tgl), .mid_o(mid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_p(input int thp, input int m, input int n);
    return (thp + 1) * (1 << n) * 10 * (m + 1);
  endfunction

  task automatic wr_reg(input bit is_ctl, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    if (is_ctl) wr_ctl = 1'b1; else wr_thp = 1'b1;
    @(negedge clk);
    wr_ctl = 1'b0; wr_thp = 1'b0;
  endtask

  // counts negedges until tgl; mid position recorded on the way
  task automatic measure(output int mid_at, output int tgl_at, output int scl_end);
    mid_at = -1; tgl_at = -1;
    for (int n = 1; n <= 20000; n++) begin
      @(negedge clk);
      if (mid && mid_at < 0) mid_at = n;
      if (tgl) begin tgl_at = n; break; end
    end
    scl_end = int'(scl);
  endtask

  task automatic start(input logic [7:0] thp_v, input logic [7:0] ctl_v);
    @(negedge clk); en = 1'b0;
    wr_reg(1'b0, thp_v);
    wr_reg(1'b1, ctl_v);
    @(negedge clk); @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    int pulses = 0;
    chk("R1 scl after reset", int'(scl), 1);
    chk("R1 tgl after reset", int'(tgl), 0);
    chk("R1 mid after reset", int'(mid), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tgl || mid) pulses++;
    end
    chk("R9 no strobes while disabled", pulses, 0);
  endtask

  task automatic t_basic;
    int ma, ta, s, p;
    p = half_p(5, 2, 0);
    start(8'd5, 8'h10);
    measure(ma, ta, s);
    chk("R3 first mid", ma, p / 2);
    chk("R3 R10 first tgl", ta, p);
    chk("R2 scl low after first toggle", s, 0);
    measure(ma, ta, s);
    chk("R4 mid at half", ma, p / 2);
    chk("R2 period", ta, p);
    chk("R2 scl high after second toggle", s, 1);
  endtask

  task automatic t_ndiv;
    int ma, ta, s, p;
    p = half_p(7, 4, 2);
    start(8'd7, 8'h22);
    measure(ma, ta, s);
    chk("R5 first tgl M=4 N=2", ta, p);
    measure(ma, ta, s);
    chk("R5 mid M=4 N=2", ma, p / 2);
    chk("R5 period M=4 N=2", ta, p);
  endtask

  task automatic t_bit7;
    int ma, ta, s;
    start(8'd7, 8'hA2);
    measure(ma, ta, s);
    measure(ma, ta, s);
    chk("R5 bit7 ignored", ta, half_p(7, 4, 2));
  endtask

  task automatic t_thp_clamp;
    int ma, ta, s;
    start(8'd2, 8'h10);
    measure(ma, ta, s);
    chk("R6 thp=2 acts as 5", ta, half_p(5, 2, 0));
    start(8'd0, 8'h10);
    measure(ma, ta, s);
    measure(ma, ta, s);
    chk("R6 thp=0 acts as 5", ta, half_p(5, 2, 0));
    chk("R6 thp=0 mid", ma, half_p(5, 2, 0) / 2);
  endtask

  task automatic t_m_clamp;
    int ma, ta, s;
    start(8'd5, 8'h01);
    measure(ma, ta, s);
    chk("R7 M=0 acts as 2", ta, half_p(5, 2, 1));
    start(8'd5, 8'h09);
    measure(ma, ta, s);
    chk("R7 M=1 acts as 2", ta, half_p(5, 2, 1));
  endtask

  task automatic t_reload;
    int ma, ta, s, p_old, p_new;
    p_old = half_p(5, 2, 0);
    p_new = half_p(11, 3, 1);
    start(8'd5, 8'h10);
    measure(ma, ta, s);
    // two writes take four negedges out of the running half period
    wr_reg(1'b0, 8'd11);
    wr_reg(1'b1, 8'h19);
    measure(ma, ta, s);
    chk("R8 running half period unchanged", ta + 4, p_old);
    measure(ma, ta, s);
    chk("R8 new mid after boundary", ma, p_new / 2);
    chk("R8 new period after boundary", ta, p_new);
  endtask

  task automatic t_disable;
    int ma, ta, s, p, pulses;
    p = half_p(5, 2, 0);
    start(8'd5, 8'h10);
    measure(ma, ta, s);
    repeat (50) @(negedge clk);
    en = 1'b0;
    pulses = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tgl || mid) pulses++;
      if (i == 2) chk("R9 scl forced high", int'(scl), 1);
    end
    chk("R9 strobes silent when disabled", pulses, 0);
    en = 1'b1;
    measure(ma, ta, s);
    chk("R9 restart mid", ma, p / 2);
    chk("R9 restart full period", ta, p);
  endtask

  initial begin
    #1_200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ndiv();
    t_bit7();
    t_thp_clamp();
    t_m_clamp();
    t_reload();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule